// File: doc/BRIEF.md
# Serial Frame Transmitter with Masked Empty Interrupt

This block turns host writes into asynchronous serial frames. A host presents a data word, a parity bit of its own choosing, an RTS level and the frame options, then releases an active-low chip-select. The block detects the release (the rising edge of `cs_n`) after synchronizing it to the local clock, and the write is latched on that edge. A one-word holding register sits in front of a shift register. A free-running `baud_tick` strobe from outside sets the bit period. The block contains no rate generator.

Each frame starts with a low start bit. The data bits follow, least significant first, and the count is either the full word or the word minus its top bit. Next comes the host's parity bit when parity is enabled, then one or two high stop bits. The `hold_tx` control turns a write into an RTS-only update that leaves the holding register untouched. The `buf_empty` flag shows when the holding register can take a new word. That flag, gated by `irq_mask`, drives `irq`.

Top module: `uart_tx_ctl`

## Requirements
- R1: Out of reset `tx` is 1, `rts` is 0 and `buf_empty` is 1; `tx` stays 1 whenever no frame is being sent.
- R2: A frame begins with one 0 bit, followed by data bits starting with bit 0; with `cfg_len7`=0 all 8 bits are sent.
- R3: With `cfg_len7`=1 only bits 0..6 are sent and bit 7 of the word is not transmitted.
- R4: With `cfg_par_en`=1 the host's `wr_parity` value is sent right after the last data bit and before the stop bits; with `cfg_par_en`=0 no bit is inserted there.
- R5: One stop bit (value 1) is sent when `cfg_two_stop`=0 and two when it is 1; `tx` changes only in the cycle after a `baud_tick`, each bit lasting one tick period.
- R6: A rising edge of `cs_n` with `hold_tx`=0 latches `wr_data`, `wr_parity` and the three format bits for a later frame, loads `rts` from `wr_rts`, and clears `buf_empty`.
- R7: A rising edge of `cs_n` with `hold_tx`=1 loads only `rts`; the holding register, `buf_empty` and the frames sent are unaffected.
- R8: `buf_empty` returns to 1 when the held word moves into the shift register; a word that is already held starts on the tick right after the previous frame's last stop bit, with no idle bit in between.
- R9: `irq` is 1 exactly when `buf_empty` and `irq_mask` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe per bit period |
| cs_n | input | 1 | Host chip-select, active low; its rising edge commits a write |
| wr_data | input | 8 | Data word to send |
| wr_parity | input | 1 | Parity bit supplied by the host |
| wr_rts | input | 1 | New RTS level |
| cfg_len7 | input | 1 | 1: drop the top data bit |
| cfg_par_en | input | 1 | 1: send the parity bit |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| hold_tx | input | 1 | 1: the write updates RTS only |
| irq_mask | input | 1 | Interrupt enable for the empty flag |
| tx | output | 1 | Serial line, idles high |
| rts | output | 1 | RTS level from the last write |
| buf_empty | output | 1 | Holding register can take a word |
| irq | output | 1 | Masked empty interrupt |

## Verification
The hardest case to reach is a word waiting in the holding register while another frame is still shifting. This case is the only way to show that the second stop bit exists, that the next start bit follows with no gap, and that an RTS-only write leaves the waiting word alone. The stimulus issues a second write and an RTS-only write a few cycles after a two-stop frame starts, well inside its 44-cycle span. The scoreboard then expects the two frames as one unbroken bit stream, so an early start or a replaced word shows up as a bit mismatch.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   // Frame options captured with each queued word
   typedef struct packed {
      logic len7;
      logic par_en;
      logic two_stop;
   } fmt_t;

endpackage

// File: rtl/uart_tx_cs_edge.sv
module uart_tx_cs_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   output logic rise
);
   logic cs_s;
   logic cs_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign cs_s = cs_n;
      end else if (SYNC_STAGES == 1) begin : g_one
         logic sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= 1'b1;
            else        sh <= cs_n;
         end
         assign cs_s = sh;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else        sh <= {sh[SYNC_STAGES-2:0], cs_n};
         end
         assign cs_s = sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_q <= 1'b1;
      else        cs_q <= cs_s;
   end

   assign rise = cs_s & ~cs_q;
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
   import uart_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              hold_tx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_parity,
   input  logic              wr_rts,
   input  fmt_t              fmt_in,
   input  logic              take,
   output logic              rts,
   output logic              full,
   output logic [DATA_W-1:0] word_data,
   output logic              word_par,
   output fmt_t              word_fmt
);
   logic load;
   assign load = rise & ~hold_tx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rts       <= 1'b0;
         full      <= 1'b0;
         word_data <= '0;
         word_par  <= 1'b0;
         word_fmt  <= '0;
      end else begin
         if (rise) rts <= wr_rts;
         if (load) begin
            word_data <= wr_data;
            word_par  <= wr_parity;
            word_fmt  <= fmt_in;
            full      <= 1'b1;
         end else if (take) begin
            full <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
   import uart_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              full,
   input  logic [DATA_W-1:0] data,
   input  logic              par,
   input  fmt_t              fmt,
   output logic              take,
   output logic              busy,
   output logic              tx
);
   localparam int FRAME_W = DATA_W + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   logic [FRAME_W-1:0] sreg;
   logic [FRAME_W-1:0] nxt_frame;
   logic [CNT_W-1:0]   cnt;
   logic [CNT_W-1:0]   nxt_len;
   logic               last;

   // Assemble start, data, optional parity and stop bits; padding is 1
   always_comb begin
      int pos;
      nxt_frame    = '1;
      nxt_frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (!(fmt.len7 && i == DATA_W - 1)) nxt_frame[1 + i] = data[i];
      end
      pos = fmt.len7 ? DATA_W : DATA_W + 1;
      if (fmt.par_en) begin
         nxt_frame[pos] = par;
         pos = pos + 1;
      end
      nxt_len = CNT_W'(pos + (fmt.two_stop ? 2 : 1));
   end

   assign last = busy && (cnt == CNT_W'(1));
   assign take = tick && full && (!busy || last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sreg <= '1;
         cnt  <= '0;
      end else if (tick) begin
         if (take) begin
            sreg <= nxt_frame;
            cnt  <= nxt_len;
            busy <= 1'b1;
         end else if (last) begin
            busy <= 1'b0;
         end else if (busy) begin
            sreg <= {1'b1, sreg[FRAME_W-1:1]};
            cnt  <= cnt - CNT_W'(1);
         end
      end
   end

   assign tx = busy ? sreg[0] : 1'b1;
endmodule

// File: rtl/uart_tx_ctl.sv
module uart_tx_ctl
   import uart_tx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              cs_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_parity,
   input  logic              wr_rts,
   input  logic              cfg_len7,
   input  logic              cfg_par_en,
   input  logic              cfg_two_stop,
   input  logic              hold_tx,
   input  logic              irq_mask,
   output logic              tx,
   output logic              rts,
   output logic              buf_empty,
   output logic              irq
);
   generate
      if (DATA_W < 5 || DATA_W > 12) begin : g_bad_width
         $error("uart_tx_ctl: DATA_W must lie in 5..12");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("uart_tx_ctl: SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   logic              cs_rise;
   logic              word_full;
   logic              frm_take;
   logic              frm_busy;
   logic [DATA_W-1:0] word_data;
   logic              word_par;
   fmt_t              word_fmt;
   fmt_t              fmt_in;

   assign fmt_in = '{len7: cfg_len7, par_en: cfg_par_en, two_stop: cfg_two_stop};

   uart_tx_cs_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
      .clk  (clk),
      .rst_n(rst_n),
      .cs_n (cs_n),
      .rise (cs_rise)
   );

   uart_tx_hold #(.DATA_W(DATA_W)) hold_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise     (cs_rise),
      .hold_tx  (hold_tx),
      .wr_data  (wr_data),
      .wr_parity(wr_parity),
      .wr_rts   (wr_rts),
      .fmt_in   (fmt_in),
      .take     (frm_take),
      .rts      (rts),
      .full     (word_full),
      .word_data(word_data),
      .word_par (word_par),
      .word_fmt (word_fmt)
   );

   uart_tx_frame #(.DATA_W(DATA_W)) frame_i (
      .clk (clk),
      .rst_n(rst_n),
      .tick(baud_tick),
      .full(word_full),
      .data(word_data),
      .par (word_par),
      .fmt (word_fmt),
      .take(frm_take),
      .busy(frm_busy),
      .tx  (tx)
   );

   assign buf_empty = ~word_full;
   assign irq       = buf_empty & irq_mask;
endmodule

// File: rtl/uart_tx_ctl_chk.sv
module uart_tx_ctl_chk (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic tx,
   input logic rts,
   input logic buf_empty,
   input logic irq,
   input logic irq_mask,
   input logic hold_tx,
   input logic rise,
   input logic busy
);
   a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> tx);

   a_r5_tx_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> $stable(tx));

   a_r6_load_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !hold_tx) |=> !buf_empty);

   a_r7_hold_keeps_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && hold_tx && buf_empty) |=> buf_empty);

   a_r7_rts_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> $stable(rts));

   a_r9_mask_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_mask |-> !irq);

   a_r9_full_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_empty |-> !irq);
endmodule

bind uart_tx_ctl uart_tx_ctl_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .baud_tick(baud_tick),
   .tx       (tx),
   .rts      (rts),
   .buf_empty(buf_empty),
   .irq      (irq),
   .irq_mask (irq_mask),
   .hold_tx  (hold_tx),
   .rise     (cs_rise),
   .busy     (frm_busy)
);

// File: tb/uart_tx_ctl_tb_top.sv
module uart_tx_ctl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       cs_n = 1'b1;
   logic [7:0] wr_data = '0;
   logic       wr_parity = 1'b0;
   logic       wr_rts = 1'b0;
   logic       cfg_len7 = 1'b0;
   logic       cfg_par_en = 1'b0;
   logic       cfg_two_stop = 1'b0;
   logic       hold_tx = 1'b0;
   logic       irq_mask = 1'b1;
   logic       tx, rts, buf_empty, irq;

   int n_chk = 0;
   int n_fail = 0;
   logic [15:0] exp_q[$];
   int          len_q[$];
   bit          in_frame = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   uart_tx_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cs_n(cs_n),
      .wr_data(wr_data), .wr_parity(wr_parity), .wr_rts(wr_rts),
      .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_two_stop(cfg_two_stop),
      .hold_tx(hold_tx), .irq_mask(irq_mask),
      .tx(tx), .rts(rts), .buf_empty(buf_empty), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // Bit period: one tick every 4 clocks, driven away from the active edge
   initial begin
      forever begin
         repeat (3) @(negedge clk);
         baud_tick = 1'b1;
         @(negedge clk);
         baud_tick = 1'b0;
      end
   end

   // Expected line bits, built from R2..R5 independently of the design
   task automatic push_frame(input logic [7:0] d, input logic p, l7, pe, ts);
      logic [15:0] b = '1;
      int n = 1;
      b[0] = 1'b0;
      for (int i = 0; i < (l7 ? 7 : 8); i++) begin
         b[n] = d[i];
         n++;
      end
      if (pe) begin
         b[n] = p;
         n++;
      end
      n = n + (ts ? 2 : 1);
      exp_q.push_back(b);
      len_q.push_back(n);
   endtask

   task automatic write(input logic [7:0] d, input logic p, r, l7, pe, ts, h);
      @(negedge clk);
      wr_data = d; wr_parity = p; wr_rts = r;
      cfg_len7 = l7; cfg_par_en = pe; cfg_two_stop = ts; hold_tx = h;
      cs_n = 1'b0;
      repeat (2) @(negedge clk);
      if (!h) push_frame(d, p, l7, pe, ts);
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic wait_idle();
      while (exp_q.size() != 0 || in_frame) @(negedge clk);
      repeat (8) @(negedge clk);
   endtask

   // Monitor: sample tx after each tick edge and compare with the scoreboard
   initial begin
      logic [15:0] cur = '0;
      int          curn = 0;
      int          idx = 0;
      forever begin
         @(posedge clk);
         if (baud_tick && rst_n) begin
            @(negedge clk);
            if (!in_frame) begin
               if (tx == 1'b0) begin
                  if (exp_q.size() == 0) begin
                     chk(1'b0, "R7 unexpected start bit", tx, 1);
                  end else begin
                     cur = exp_q.pop_front();
                     curn = len_q.pop_front();
                     chk(tx == 1'b0, "R2 start bit", tx, 0);
                     idx = 1;
                     in_frame = 1'b1;
                  end
               end
            end else begin
               chk(tx == cur[idx], $sformatf("R2 R3 R4 R5 R8 frame bit %0d", idx), tx, cur[idx]);
               idx++;
               if (idx == curn) in_frame = 1'b0;
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1 R9: reset state
      chk(tx == 1'b1, "R1 tx in reset", tx, 1);
      chk(rts == 1'b0, "R1 rts in reset", rts, 0);
      chk(buf_empty == 1'b1, "R1 empty in reset", buf_empty, 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(irq == 1'b1, "R9 irq with mask set", irq, 1);
      irq_mask = 1'b0;
      @(negedge clk);
      chk(irq == 1'b0, "R9 irq masked", irq, 0);
      irq_mask = 1'b1;

      // R2 R5 R6: 8 bits, no parity, one stop, rts raised
      write(8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      chk(rts == 1'b1, "R6 rts loaded", rts, 1);
      wait_idle();
      // R3: 7 bits, top bit of 0xD3 dropped
      write(8'hD3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      wait_idle();
      // R4: host parity 1 with 8 bits, parity 0 with 7 bits
      write(8'h0F, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      wait_idle();
      write(8'h7E, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
      wait_idle();

      // R5 R8: two-stop frame with the next word waiting behind it
      write(8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      write(8'h81, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      chk(buf_empty == 1'b0, "R6 empty cleared by load", buf_empty, 0);
      chk(irq == 1'b0, "R9 irq low while full", irq, 0);
      // R7: rts-only write while a word waits
      write(8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      chk(rts == 1'b0, "R7 rts updated by hold write", rts, 0);
      chk(buf_empty == 1'b0, "R7 waiting word kept", buf_empty, 0);
      wait_idle();
      chk(buf_empty == 1'b1, "R8 empty set after transfer", buf_empty, 1);
      chk(irq == 1'b1, "R9 irq when empty", irq, 1);

      // R7: rts-only write while idle queues nothing
      write(8'h55, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      chk(rts == 1'b1, "R7 rts updated while idle", rts, 1);
      repeat (40) begin
         @(negedge clk);
         if (buf_empty != 1'b1 || tx != 1'b1)
            chk(1'b0, "R7 idle after hold write", {buf_empty, tx}, 3);
      end
      chk(buf_empty == 1'b1 && tx == 1'b1, "R7 line idle and empty", {buf_empty, tx}, 3);
      chk(exp_q.size() == 0 && !in_frame, "R8 scoreboard drained", exp_q.size(), 0);

      summary();
      $finish;
   end
endmodule